// File: doc/BRIEF.md
# Latched Position Output Byte Interface

This block places the value of a free-running position counter onto a shared 16-line three-state data bus. It keeps a copy of the counter in an output latch. The latch takes the counter value on every counter-update strobe. A freeze input, active low, stops the latch from taking new values. The counter keeps moving while the latch is frozen, so the tracking loop never stalls. When the freeze is released, the block raises a one-cycle refresh request and reloads the latch from the live counter.

A read-enable input, active low, turns on the bus drivers. The low half of the bus always carries the low byte. The high half carries either the high byte or a second copy of the low byte, as a byte-select input chooses. This lets an 8-bit host read both bytes from one set of lines. A resolution code sets how many counter bits are meaningful. The latch stores every bit above that width as zero. All control inputs are synchronous and are sampled on the rising clock edge.

Top module: `pos_byte_latch`

## Requirements
- R1: After reset the latch holds zero, bus_oe is all zero, bus_data is all zero and refresh_req is low.
- R2: At a rising edge where cnt_upd is 1 and hold_n is 1, the latch takes cnt_val, masked to the resolution. The new value is on bus_data after that same edge.
- R3: At every rising edge where hold_n is 0, the latch keeps its value, even while cnt_upd pulses and cnt_val changes.
- R4: When hold_n is sampled 1 at an edge after being sampled 0 at the edge before, refresh_req is 1 for exactly one cycle. At the next edge the latch loads the current cnt_val, with or without cnt_upd.
- R5: With read_en_n sampled 1, all 16 bits of bus_oe are 0 and bus_data is 0. With read_en_n sampled 0, all 16 bits of bus_oe are 1. Each change is seen after the sampling edge.
- R6: bus_data[7:0] carries latch bits [7:0] while driven, whatever hi_sel is.
- R7: With hi_sel sampled 1, bus_data[15:8] carries latch bits [15:8]. With hi_sel sampled 0, bus_data[15:8] repeats latch bits [7:0].
- R8: res_code selects a width of 10 + 2*res_code bits (0 gives 10, 1 gives 12, 2 gives 14, 3 gives 16). Latch bits at or above that width are stored as 0, so the unused lines are driven low.
- R9: read_en_n and hi_sel have no effect on latching. Updates made while the bus is off or hi_sel toggles appear as soon as the bus is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | 16 | Live position counter value |
| cnt_upd | input | 1 | Counter-update strobe, one cycle per step |
| hold_n | input | 1 | Latch freeze, active low |
| read_en_n | input | 1 | Bus drive enable, active low |
| hi_sel | input | 1 | 1: high byte on upper lines, 0: low byte repeated |
| res_code | input | 2 | Resolution code, width = 10 + 2*code |
| bus_data | output | 16 | Data toward the bus, bits [15:8] are the upper group |
| bus_oe | output | 16 | Per-line output enable, 1 drives the line |
| refresh_req | output | 1 | One-cycle refresh strobe after the freeze is released |

## Verification
Every result here is due one rising edge after its stimulus. A latch load, a change of freeze, a change of enable and a change of byte select all appear after the first edge that samples them. The refresh reload is the one exception: it lands one edge after refresh_req, so two edges after hold_n rises. The bench drives inputs on the falling edge and advances one rising edge. It samples on the next falling edge, so every check reads the value due after exactly the counted number of edges. During the frozen two-byte read, the counter strobes on every cycle. The bench checks both bytes against the value captured before the freeze.

// File: rtl/pos_byte_latch.sv
module pos_byte_latch #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int MIN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              cnt_upd,
  input  logic              hold_n,
  input  logic              read_en_n,
  input  logic              hi_sel,
  input  logic [1:0]        res_code,
  output logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] bus_oe,
  output logic              refresh_req
);
  localparam int SHIFT_MAX = DATA_W - MIN_W;

  logic [DATA_W-1:0] lat;
  logic [DATA_W-1:0] res_mask;
  logic              hold_q;
  logic              drive_q;
  logic              hi_q;
  logic              load;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;

  assign res_mask = {DATA_W{1'b1}} >> (SHIFT_MAX - 2 * int'(res_code));
  assign load     = hold_n && (cnt_upd || refresh_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat         <= '0;
      hold_q      <= 1'b1;
      refresh_req <= 1'b0;
      drive_q     <= 1'b0;
      hi_q        <= 1'b0;
    end else begin
      hold_q      <= hold_n;
      refresh_req <= hold_n && !hold_q;
      drive_q     <= !read_en_n;
      hi_q        <= hi_sel;
      if (load) lat <= cnt_val & res_mask;
    end
  end

  assign lo_byte  = lat[BYTE_W-1:0];
  assign hi_byte  = hi_q ? lat[DATA_W-1:DATA_W-BYTE_W] : lo_byte;
  assign bus_data = drive_q ? {hi_byte, lo_byte} : '0;
  assign bus_oe   = {DATA_W{drive_q}};

  assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> lat == $past(lat));

  assert_refresh_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  assert_refresh_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && hold_n) |=> lat == $past(cnt_val & res_mask));

  assert_update_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_upd && hold_n) |=> lat == $past(cnt_val & res_mask));

  assert_oe_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == '0) || (bus_oe == '1));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe == '0) |-> (bus_data == '0));

  assert_dup_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe[0] && !hi_q) |-> bus_data[DATA_W-1:DATA_W-BYTE_W] == bus_data[BYTE_W-1:0]);
endmodule

// File: tb/test_pos_byte_latch.sv
module test_pos_byte_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_upd = 1'b0;
  logic        hold_n = 1'b1;
  logic        read_en_n = 1'b1;
  logic        hi_sel = 1'b0;
  logic [1:0]  res_code = 2'd3;
  logic [15:0] bus_data;
  logic [15:0] bus_oe;
  logic        refresh_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pos_byte_latch i_pos_byte_latch (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
    .hold_n(hold_n), .read_en_n(read_en_n), .hi_sel(hi_sel),
    .res_code(res_code), .bus_data(bus_data), .bus_oe(bus_oe),
    .refresh_req(refresh_req));

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] rc);
    int w = 10 + 2 * int'(rc);
    logic [15:0] m = '0;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    return v & m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oe", bus_oe, 32'h0);
    check("R1 data", bus_data, 32'h0);
    check("R1 refresh", refresh_req, 32'h0);
    read_en_n = 1'b0; hi_sel = 1'b1;
    step();
    check("R1 latch zero", bus_data, 32'h0);
  endtask

  task automatic t_load();
    res_code = 2'd3; read_en_n = 1'b0; hi_sel = 1'b1;
    cnt_val = 16'hA5C3; cnt_upd = 1'b1;
    step();
    cnt_upd = 1'b0;
    check("R2 load", bus_data, 32'hA5C3);
    check("R6 low byte", bus_data[7:0], 32'hC3);
    cnt_val = 16'h1234;
    step();
    check("R2 no strobe keeps", bus_data, 32'hA5C3);
  endtask

  task automatic t_frozen_read();
    logic [15:0] held;
    cnt_val = 16'h3C7E; cnt_upd = 1'b1;
    step();
    held = 16'h3C7E;
    hold_n = 1'b0; cnt_val = 16'h3C7F;
    step();
    check("R3 freeze edge", bus_data, {16'h0, held});
    hi_sel = 1'b1; cnt_val = 16'h4000;
    step();
    check("R3 high byte read", bus_data[15:8], {24'h0, held[15:8]});
    check("R6 low byte frozen", bus_data[7:0], {24'h0, held[7:0]});
    hi_sel = 1'b0; cnt_val = 16'hFFEE;
    step();
    check("R7 dup low frozen", bus_data[15:8], {24'h0, held[7:0]});
    check("R3 low byte read", bus_data[7:0], {24'h0, held[7:0]});
    check("R4 no refresh while frozen", refresh_req, 32'h0);
  endtask

  task automatic t_release();
    cnt_upd = 1'b0; cnt_val = 16'h5A01; hi_sel = 1'b1; hold_n = 1'b1;
    step();
    check("R4 refresh raised", refresh_req, 32'h1);
    check("R4 not yet loaded", bus_data, 32'h3C7E);
    cnt_val = 16'h5A02;
    step();
    check("R4 refresh single", refresh_req, 32'h0);
    check("R4 refresh loads", bus_data, 32'h5A02);
    cnt_val = 16'h5A03;
    step();
    check("R4 no second load", bus_data, 32'h5A02);
  endtask

  task automatic t_enable();
    read_en_n = 1'b1;
    step();
    check("R5 off oe", bus_oe, 32'h0);
    check("R5 off data", bus_data, 32'h0);
    read_en_n = 1'b0;
    step();
    check("R5 on oe", bus_oe, 32'hFFFF);
  endtask

  task automatic t_bytesel();
    cnt_val = 16'hBEEF; cnt_upd = 1'b1; hi_sel = 1'b0;
    step();
    cnt_upd = 1'b0;
    check("R7 dup", bus_data, 32'hEFEF);
    check("R6 low with sel0", bus_data[7:0], 32'hEF);
    hi_sel = 1'b1;
    step();
    check("R7 high", bus_data, 32'hBEEF);
    check("R6 low with sel1", bus_data[7:0], 32'hEF);
  endtask

  task automatic t_resolution();
    for (int rc = 0; rc < 4; rc++) begin
      res_code = 2'(rc); cnt_val = 16'hFFFF; cnt_upd = 1'b1; hi_sel = 1'b1;
      step();
      check($sformatf("R8 res %0d", rc), bus_data, {16'h0, masked(16'hFFFF, 2'(rc))});
    end
    res_code = 2'd1; cnt_val = 16'hF0F0;
    step();
    cnt_upd = 1'b0;
    check("R8 res 1 pattern", bus_data, 32'h00F0);
    res_code = 2'd3;
  endtask

  task automatic t_no_effect();
    read_en_n = 1'b1; cnt_val = 16'h7711; cnt_upd = 1'b1; hi_sel = 1'b0;
    step();
    cnt_val = 16'h7722; hi_sel = 1'b1;
    step();
    cnt_upd = 1'b0; hi_sel = 1'b0;
    step();
    check("R9 off still quiet", bus_data, 32'h0);
    read_en_n = 1'b0; hi_sel = 1'b1;
    step();
    check("R9 update while off", bus_data, 32'h7722);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_frozen_read();
    t_release();
    t_enable();
    t_bytesel();
    t_resolution();
    t_no_effect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule